// File: doc/BRIEF.md
# Bridge I/O Window Router and Error Reporter

This block is the decision logic of a host-to-PCI Express bridge port. Each processor I/O request carries a 16-bit port address. The block checks that address against a programmable window and then answers with one route: down the PCI Express link, or to the legacy downstream path. On the legacy path, an ISA bridge is free to claim the cycle. A single exclusion enable can withhold ISA alias addresses from the link. These are the addresses whose offset inside their 1 KB block lies in the upper 768 bytes.

The same block also handles error reporting. It turns error messages received from the secondary side into one-cycle system-error requests. A global enable gates this, and so does a per-severity enable. The block also keeps a sticky status bit that records poisoned read completions arriving upstream, when parity error response is enabled. Software programs the block through a narrow write port: a select, a data byte and a strobe.

Top module: `bridge_io_err_ctl`

## Requirements
- R1: A request accepted with `io_req_valid` produces `io_rsp_valid` exactly one cycle later. With ISA exclusion off, every address inside the window gets `io_rsp_to_link`=1.
- R2: With ISA exclusion on, an in-window address whose bits [9:8] are not 00 is routed to legacy (`io_rsp_to_link`=0). An in-window address with bits [9:8]=00 still goes to the link.
- R3: The window holds when base <= addr[15:12] <= limit, with both bounds inclusive. A base greater than the limit disables the window.
- R4: An address outside the window is always routed to legacy, whatever the ISA exclusion bit holds.
- R5: While the system-error enable is 0, no error message ever raises `sys_err_req`.
- R6: While the system-error enable is 1, an error message of kind correctable (0), non-fatal (1) or fatal (2) pulses `sys_err_req` for exactly one cycle, on the cycle after the message. This happens only when the root enable for that kind is set. Kind 3 never raises it.
- R7: An upstream poisoned read completion sets `mdpe_status` on the following cycle when parity response enable is 1. While that enable is 0, `mdpe_status` never becomes set.
- R8: `mdpe_status` stays set until a status write with data bit 0 = 1 clears it. If a clear and a new set arrive in the same cycle, the bit stays set.
- R9: After reset, all control bits and root enables are 0, the window is disabled (base=F, limit=0), and `mdpe_status`, `sys_err_req` and `io_rsp_valid` are 0.
- R10: Register writes take effect on the cycle after the strobe. The select values are: 0 = control (bit0 parity response enable, bit1 system-error enable, bit2 ISA exclusion), 1 = window (bits[3:0] base, bits[7:4] limit), 2 = root enables (bit0 correctable, bit1 non-fatal, bit2 fatal), 3 = status clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select |
| cfg_wr_data | input | 8 | Register write data |
| io_req_valid | input | 1 | Processor I/O request present |
| io_req_addr | input | 16 | I/O port address of the request |
| io_rsp_valid | output | 1 | Routing decision valid (one cycle after request) |
| io_rsp_to_link | output | 1 | 1 = forward to PCI Express, 0 = legacy path |
| err_msg_valid | input | 1 | Error message received from secondary side |
| err_msg_kind | input | 2 | 0 correctable, 1 non-fatal, 2 fatal, 3 reserved |
| cpl_poison_valid | input | 1 | Poisoned read-data completion received upstream |
| sys_err_req | output | 1 | One-cycle system-error request |
| mdpe_status | output | 1 | Sticky master data parity error status |

## Verification
The assertions are checked on every cycle. They cover the following: legacy routing of out-of-window and ISA-alias addresses, the one-cycle request-to-response latency, the gating of system-error pulses by both enables, the rule that the parity status can rise only from an enabled poisoned completion, and its stickiness against anything but a clear write. The bench scenarios are needed for the rest. These are inclusive window bounds, the inverted window, the exact set-wins-over-clear collision, the single-cycle width of each pulse, and the reset values. Randomised traffic checks routing against a model across many window and exclusion settings.

// File: rtl/bioe_pkg.sv
package bioe_pkg;

    localparam int ADDR_W    = 16;
    localparam int WIN_LSB   = 12;
    localparam int WIN_W     = ADDR_W - WIN_LSB;
    localparam int ALIAS_LSB = 8;
    localparam int ALIAS_W   = 2;
    localparam int CFG_W     = 2 * WIN_W;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_WIN  = 2'd1,
        SEL_ROOT = 2'd2,
        SEL_STAT = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ERR_COR      = 2'd0,
        ERR_NONFATAL = 2'd1,
        ERR_FATAL    = 2'd2,
        ERR_RSVD     = 2'd3
    } err_kind_e;

    typedef struct packed {
        logic isa_excl;
        logic serr_en;
        logic par_en;
    } ctrl_t;

    typedef struct packed {
        logic [WIN_W-1:0] limit;
        logic [WIN_W-1:0] base;
    } win_t;

    typedef struct packed {
        logic fatal_en;
        logic nonfatal_en;
        logic cor_en;
    } root_t;

    function automatic logic in_window(input win_t w, input logic [WIN_W-1:0] page);
        return (page >= w.base) && (page <= w.limit);
    endfunction

    function automatic logic is_isa_alias(input logic [ALIAS_W-1:0] sub);
        return sub != '0;
    endfunction

    function automatic logic kind_enabled(input root_t r, input err_kind_e k);
        logic en;
        case (k)
            ERR_COR:      en = r.cor_en;
            ERR_NONFATAL: en = r.nonfatal_en;
            ERR_FATAL:    en = r.fatal_en;
            default:      en = 1'b0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/bioe_cfg.sv
module bioe_cfg
    import bioe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    output ctrl_t            ctrl,
    output win_t             win,
    output root_t            root,
    output logic             stat_clr
);
    cfg_sel_e sel;
    assign sel = cfg_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl       <= '0;
            root       <= '0;
            win.base   <= '1;
            win.limit  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: begin
                    ctrl.par_en   <= wr_data[0];
                    ctrl.serr_en  <= wr_data[1];
                    ctrl.isa_excl <= wr_data[2];
                end
                SEL_WIN: begin
                    win.base  <= wr_data[WIN_W-1:0];
                    win.limit <= wr_data[CFG_W-1:WIN_W];
                end
                SEL_ROOT: begin
                    root.cor_en      <= wr_data[0];
                    root.nonfatal_en <= wr_data[1];
                    root.fatal_en    <= wr_data[2];
                end
                default: ;
            endcase
        end
    end

    assign stat_clr = wr_en && (sel == SEL_STAT) && wr_data[0];

endmodule

// File: rtl/bioe_io_decode.sv
module bioe_io_decode
    import bioe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  ctrl_t             ctrl,
    input  win_t              win,
    output logic              rsp_valid,
    output logic              rsp_to_link
);
    logic hit;
    logic alias_hit;
    logic to_link;
    logic unused_addr_bits;

    assign hit       = in_window(win, req_addr[ADDR_W-1:WIN_LSB]);
    assign alias_hit = is_isa_alias(req_addr[ALIAS_LSB+ALIAS_W-1:ALIAS_LSB]);
    assign to_link   = hit && !(ctrl.isa_excl && alias_hit);
    assign unused_addr_bits = ^{req_addr[WIN_LSB-1:ALIAS_LSB+ALIAS_W], req_addr[ALIAS_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_to_link <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_to_link <= req_valid && to_link;
        end
    end

endmodule

// File: rtl/bioe_err_fwd.sv
module bioe_err_fwd
    import bioe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       msg_valid,
    input  logic [1:0] msg_kind,
    input  logic       poison,
    input  ctrl_t      ctrl,
    input  root_t      root,
    input  logic       stat_clr,
    output logic       serr_pulse,
    output logic       mdpe
);
    logic qualify;
    logic mdpe_set;

    assign qualify  = msg_valid && ctrl.serr_en && kind_enabled(root, err_kind_e'(msg_kind));
    assign mdpe_set = poison && ctrl.par_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            serr_pulse <= 1'b0;
            mdpe       <= 1'b0;
        end else begin
            serr_pulse <= qualify;
            if (mdpe_set)
                mdpe <= 1'b1;
            else if (stat_clr)
                mdpe <= 1'b0;
        end
    end

endmodule

// File: rtl/bridge_io_err_ctl.sv
module bridge_io_err_ctl
    import bioe_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr_en,
    input  logic [1:0]               cfg_wr_sel,
    input  logic [bioe_pkg::CFG_W-1:0]  cfg_wr_data,
    input  logic                     io_req_valid,
    input  logic [bioe_pkg::ADDR_W-1:0] io_req_addr,
    output logic                     io_rsp_valid,
    output logic                     io_rsp_to_link,
    input  logic                     err_msg_valid,
    input  logic [1:0]               err_msg_kind,
    input  logic                     cpl_poison_valid,
    output logic                     sys_err_req,
    output logic                     mdpe_status
);
    ctrl_t ctrl_q;
    win_t  win_q;
    root_t root_q;
    logic  stat_clr;

    bioe_cfg i_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_sel),
        .wr_data  (cfg_wr_data),
        .ctrl     (ctrl_q),
        .win      (win_q),
        .root     (root_q),
        .stat_clr (stat_clr)
    );

    bioe_io_decode i_dec (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (io_req_valid),
        .req_addr    (io_req_addr),
        .ctrl        (ctrl_q),
        .win         (win_q),
        .rsp_valid   (io_rsp_valid),
        .rsp_to_link (io_rsp_to_link)
    );

    bioe_err_fwd i_err (
        .clk        (clk),
        .rst        (rst),
        .msg_valid  (err_msg_valid),
        .msg_kind   (err_msg_kind),
        .poison     (cpl_poison_valid),
        .ctrl       (ctrl_q),
        .root       (root_q),
        .stat_clr   (stat_clr),
        .serr_pulse (sys_err_req),
        .mdpe       (mdpe_status)
    );

endmodule

// File: rtl/bioe_chk.sv
module bioe_chk
    import bioe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              io_req_valid,
    input logic [ADDR_W-1:0] io_req_addr,
    input logic              io_rsp_valid,
    input logic              io_rsp_to_link,
    input logic              err_msg_valid,
    input logic [1:0]        err_msg_kind,
    input logic              cpl_poison_valid,
    input logic              sys_err_req,
    input logic              mdpe_status,
    input logic              stat_clr,
    input ctrl_t             ctrl_q,
    input win_t              win_q,
    input root_t             root_q
);
    logic [WIN_W-1:0] page;
    logic             outside;
    logic             alias_sub;
    logic             kind_ok;

    assign page      = io_req_addr[ADDR_W-1:WIN_LSB];
    assign outside   = (page < win_q.base) || (page > win_q.limit);
    assign alias_sub = io_req_addr[ALIAS_LSB+1] | io_req_addr[ALIAS_LSB];
    assign kind_ok   = (err_msg_kind == 2'd0 && root_q.cor_en) ||
                       (err_msg_kind == 2'd1 && root_q.nonfatal_en) ||
                       (err_msg_kind == 2'd2 && root_q.fatal_en);

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
        io_req_valid |=> io_rsp_valid); // R1

    AST_OUTSIDE_TO_LEGACY: assert property (@(posedge clk) disable iff (rst)
        (io_req_valid && outside) |=> !io_rsp_to_link); // R4

    AST_ALIAS_TO_LEGACY: assert property (@(posedge clk) disable iff (rst)
        (io_req_valid && ctrl_q.isa_excl && alias_sub) |=> !io_rsp_to_link); // R2

    AST_SERR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.serr_en |=> !sys_err_req); // R5

    AST_SERR_NEEDS_KIND: assert property (@(posedge clk) disable iff (rst)
        !(err_msg_valid && kind_ok) |=> !sys_err_req); // R6

    AST_MDPE_SET_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !(cpl_poison_valid && ctrl_q.par_en) && !mdpe_status |=> !mdpe_status); // R7

    AST_MDPE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (mdpe_status && !stat_clr) |=> mdpe_status); // R8

endmodule

bind bridge_io_err_ctl bioe_chk i_chk (
    .clk              (clk),
    .rst              (rst),
    .io_req_valid     (io_req_valid),
    .io_req_addr      (io_req_addr),
    .io_rsp_valid     (io_rsp_valid),
    .io_rsp_to_link   (io_rsp_to_link),
    .err_msg_valid    (err_msg_valid),
    .err_msg_kind     (err_msg_kind),
    .cpl_poison_valid (cpl_poison_valid),
    .sys_err_req      (sys_err_req),
    .mdpe_status      (mdpe_status),
    .stat_clr         (stat_clr),
    .ctrl_q           (ctrl_q),
    .win_q            (win_q),
    .root_q           (root_q)
);

// File: tb/test_bridge_io_err_ctl.sv
module test_bridge_io_err_ctl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic        io_req_valid = 1'b0;
    logic [15:0] io_req_addr = '0;
    logic        io_rsp_valid;
    logic        io_rsp_to_link;
    logic        err_msg_valid = 1'b0;
    logic [1:0]  err_msg_kind = '0;
    logic        cpl_poison_valid = 1'b0;
    logic        sys_err_req;
    logic        mdpe_status;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // shadow configuration
    logic [3:0] m_base = 4'hF, m_limit = 4'h0;
    logic m_isa = 0, m_serr = 0, m_par = 0;
    logic [2:0] m_root = '0;

    always #10 clk = ~clk;

    bridge_io_err_ctl i_bridge_io_err_ctl (
        .clk, .rst, .cfg_wr_en, .cfg_wr_sel, .cfg_wr_data,
        .io_req_valid, .io_req_addr, .io_rsp_valid, .io_rsp_to_link,
        .err_msg_valid, .err_msg_kind, .cpl_poison_valid,
        .sys_err_req, .mdpe_status
    );

    function automatic logic exp_link(input logic [15:0] a);
        logic inwin;
        inwin = (a[15:12] >= m_base) && (a[15:12] <= m_limit);
        return inwin && !(m_isa && (a[9:8] != 2'b00));
    endfunction

    function automatic logic exp_serr(input logic [1:0] k);
        return m_serr && (k != 2'd3) && m_root[k];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 0;
        case (sel)
            2'd0: begin m_par = d[0]; m_serr = d[1]; m_isa = d[2]; end
            2'd1: begin m_base = d[3:0]; m_limit = d[7:4]; end
            2'd2: m_root = d[2:0];
            default: ;
        endcase
    endtask

    task automatic io(input string req, input logic [15:0] a);
        @(negedge clk);
        io_req_valid = 1; io_req_addr = a;
        @(negedge clk);
        io_req_valid = 0;
        check(req, io_rsp_valid, 1'b1);
        check(req, io_rsp_to_link, exp_link(a));
    endtask

    task automatic err(input string req, input logic [1:0] k);
        @(negedge clk);
        err_msg_valid = 1; err_msg_kind = k;
        @(negedge clk);
        err_msg_valid = 0;
        check(req, sys_err_req, exp_serr(k));
        @(negedge clk);
        check(req, sys_err_req, 1'b0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        check("R9 rsp_valid", io_rsp_valid, 1'b0);
        check("R9 sys_err", sys_err_req, 1'b0);
        check("R9 mdpe", mdpe_status, 1'b0);
        io("R9 window disabled at reset", 16'h0000);
        io("R9 window disabled at reset", 16'hF3FF);
        err("R9 serr off at reset", 2'd2);

        // R10/R3 window programming, inclusive bounds
        wr(2'd1, 8'h52);             // base 2, limit 5
        io("R3 lower bound", 16'h2000);
        io("R3 upper bound", 16'h5FFF);
        io("R4 below window", 16'h1FFF);
        io("R4 above window", 16'h6000);
        io("R1 in window isa off alias", 16'h3300);
        // R2 ISA exclusion
        wr(2'd0, 8'h04);
        io("R2 alias excluded", 16'h3100);
        io("R2 alias excluded", 16'h3E00);
        io("R2 non-alias kept", 16'h34FF);
        io("R4 outside with isa", 16'h7000);
        // R3 inverted window
        wr(2'd1, 8'h36);
        io("R3 base>limit disables", 16'h4000);
        io("R3 base>limit disables", 16'h3000);
        wr(2'd1, 8'h77);
        io("R3 single page", 16'h7400);

        // R5 serr gated globally
        wr(2'd2, 8'h07);
        wr(2'd0, 8'h00);
        for (int k = 0; k < 4; k++) err("R5 serr disabled", 2'(k));
        // R6 per-kind
        wr(2'd0, 8'h02);
        for (int k = 0; k < 4; k++) err("R6 all kinds enabled", 2'(k));
        wr(2'd2, 8'h02);
        for (int k = 0; k < 4; k++) err("R6 only nonfatal", 2'(k));
        // R6 back-to-back messages give one pulse each cycle
        wr(2'd2, 8'h05);
        @(negedge clk); err_msg_valid = 1; err_msg_kind = 2'd0;
        @(negedge clk); err_msg_kind = 2'd1;
        check("R6 b2b first", sys_err_req, 1'b1);
        @(negedge clk); err_msg_valid = 0;
        check("R6 b2b masked kind", sys_err_req, 1'b0);

        // R7 parity disabled: never set
        wr(2'd0, 8'h00);
        @(negedge clk); cpl_poison_valid = 1;
        @(negedge clk); cpl_poison_valid = 0;
        check("R7 par disabled no set", mdpe_status, 1'b0);
        wr(2'd0, 8'h01);
        @(negedge clk); cpl_poison_valid = 1;
        @(negedge clk); cpl_poison_valid = 0;
        check("R7 poisoned sets", mdpe_status, 1'b1);
        // R8 sticky
        wr(2'd3, 8'h00);
        check("R8 write 0 keeps", mdpe_status, 1'b1);
        wr(2'd0, 8'h00);
        check("R8 enable off keeps", mdpe_status, 1'b1);
        wr(2'd3, 8'h01);
        check("R8 w1c clears", mdpe_status, 1'b0);
        // R8 set wins over clear
        wr(2'd0, 8'h01);
        @(negedge clk);
        cpl_poison_valid = 1; cfg_wr_en = 1; cfg_wr_sel = 2'd3; cfg_wr_data = 8'h01;
        @(negedge clk);
        cpl_poison_valid = 0; cfg_wr_en = 0;
        check("R8 set wins", mdpe_status, 1'b1);

        // R1-style random routing
        for (int i = 0; i < 300; i++) begin
            if (i % 10 == 0) begin
                wr(2'd1, 8'($urandom));
                wr(2'd0, {5'd0, 1'($urandom), 2'b01});
            end
            io("R1 random route", 16'($urandom));
        end
        // R6 random errors
        for (int i = 0; i < 40; i++) begin
            if (i % 5 == 0) begin
                wr(2'd2, 8'($urandom));
                wr(2'd0, {5'd0, 1'b0, 1'($urandom), 1'b0});
            end
            err("R6 random error", 2'($urandom));
        end

        done = 1;
        finish_run();
    end

endmodule